// File: doc/BRIEF.md
# Signed Branch Condition Evaluator

This block decides whether a two-register conditional branch is taken on a 32-bit multicycle processor that shares a single data bus. While the ALU places the difference SR1 minus SR2 on the bus, the evaluator looks only at that bus word and at a per-instruction test-mode bit. It has no comparator inputs of its own. From these it forms a single condition bit in the same cycle.

The mode bit picks between a greater-or-equal test and a less-or-equal test. In both modes the test reports true for a zero difference. Operands are treated as signed two's complement. Subtraction overflow is not corrected, so results near the extremes follow the sign bit only. When the microcode raises a load strobe, the condition bit is stored into a flag register, which the microsequencer then reads to choose the branch path.

Top module: `branch_cond_unit`

## Requirements
- R1: With mode = 0 (greater-or-equal), `cond_now` is 1 whenever bit 31 of `bus_diff` is 0, including a zero difference.
- R2: With mode = 0, `cond_now` is 0 whenever bit 31 of `bus_diff` is 1.
- R3: With mode = 1 (less-or-equal), `cond_now` is 1 whenever bit 31 of `bus_diff` is 1.
- R4: With mode = 1, `cond_now` is 1 when all 32 bits of `bus_diff` are zero.
- R5: With mode = 1, `cond_now` is 0 when `bus_diff` is non-zero and bit 31 is 0, whichever bits are set.
- R6: `cond_now` is combinational and follows `bus_diff` and `cmp_mode` within the same cycle, with no clock edge in the path.
- R7: When `cmp_load` is 1 at a rising clock edge, `cond_flag` shows the value `cond_now` had before that edge, starting right after the edge.
- R8: When `cmp_load` is 0 at a rising clock edge, `cond_flag` keeps its value, whatever the bus and mode do.
- R9: A synchronous active-high `rst` clears `cond_flag` to 0 and takes priority over `cmp_load`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_diff | input | 32 | Bus word holding SR1 minus SR2 |
| cmp_mode | input | 1 | 0 = greater-or-equal test, 1 = less-or-equal test |
| cmp_load | input | 1 | Microcode strobe that stores the condition into the flag |
| cond_now | output | 1 | Combinational condition for the current bus word |
| cond_flag | output | 1 | Registered branch condition for the sequencer |

## Verification
The case that is hardest to reach is the less-or-equal test on a positive difference where only a single high-order bit is set. A zero detector that misses a segment of the word would wrongly report that difference as equal. The stimulus table includes differences whose only set bit lies in different chunks of the zero-detect tree. It also includes the wrap-around extremes 0x7FFFFFFF and 0x80000000, in both modes. Flag holding is checked by changing the bus so that the live condition flips while the load strobe is low.

// File: rtl/branch_cond_pkg.sv
package branch_cond_pkg;
  typedef enum logic {
    CMP_GE = 1'b0,
    CMP_LE = 1'b1
  } cmp_mode_e;
endpackage

// File: rtl/diff_status.sv
module diff_status #(
  parameter int WIDTH = 32,
  parameter int CHUNK = 8
) (
  input  logic [WIDTH-1:0] diff,
  output logic             is_neg,
  output logic             is_zero
);
  localparam int NCHUNK = (WIDTH + CHUNK - 1) / CHUNK;
  localparam int PADW   = NCHUNK * CHUNK;

  logic [PADW-1:0]   padded;
  logic [NCHUNK-1:0] chunk_any;

  always_comb begin
    padded = '0;
    padded[WIDTH-1:0] = diff;
  end

  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign chunk_any[g] = |padded[g*CHUNK +: CHUNK];
  end

  assign is_zero = ~|chunk_any;
  assign is_neg  = diff[WIDTH-1];
endmodule

// File: rtl/cond_select.sv
module cond_select
  import branch_cond_pkg::*;
(
  input  cmp_mode_e mode,
  input  logic      is_neg,
  input  logic      is_zero,
  output logic      cond
);
  always_comb begin
    unique case (mode)
      CMP_GE:  cond = ~is_neg;
      CMP_LE:  cond = is_neg | is_zero;
      default: cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/cond_flag_reg.sv
module cond_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (load) q <= d;
  end

  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    (load) |=> (q == $past(d)));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> $stable(q));
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (q == 1'b0));
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
  import branch_cond_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ZERO_CHUNK = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_diff,
  input  logic              cmp_mode,
  input  logic              cmp_load,
  output logic              cond_now,
  output logic              cond_flag
);
  logic neg_w;
  logic zero_w;

  diff_status #(.WIDTH(DATA_W), .CHUNK(ZERO_CHUNK)) u_status (
    .diff    (bus_diff),
    .is_neg  (neg_w),
    .is_zero (zero_w)
  );

  cond_select u_sel (
    .mode    (cmp_mode_e'(cmp_mode)),
    .is_neg  (neg_w),
    .is_zero (zero_w),
    .cond    (cond_now)
  );

  cond_flag_reg u_flag (
    .clk  (clk),
    .rst  (rst),
    .load (cmp_load),
    .d    (cond_now),
    .q    (cond_flag)
  );

  // R1 / R2: greater-or-equal follows the sign bit
  a_r1_ge_nonneg: assert property (@(posedge clk) disable iff (rst)
    (!cmp_mode && !bus_diff[DATA_W-1]) |-> cond_now);
  a_r2_ge_neg: assert property (@(posedge clk) disable iff (rst)
    (!cmp_mode && bus_diff[DATA_W-1]) |-> !cond_now);
  // R3 / R4 / R5: less-or-equal
  a_r3_le_neg: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode && bus_diff[DATA_W-1]) |-> cond_now);
  a_r4_le_zero: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode && (bus_diff == '0)) |-> cond_now);
  a_r5_le_pos: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode && !bus_diff[DATA_W-1] && (bus_diff != '0)) |-> !cond_now);
endmodule

// File: tb/branch_cond_unit_test.sv
module branch_cond_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] bus_diff;
  logic        cmp_mode;
  logic        cmp_load;
  logic        cond_now;
  logic        cond_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;  // 250 MHz

  branch_cond_unit uut (
    .clk(clk), .rst(rst), .bus_diff(bus_diff), .cmp_mode(cmp_mode),
    .cmp_load(cmp_load), .cond_now(cond_now), .cond_flag(cond_flag)
  );

  // {mode, bus word, expected condition}
  localparam int NV = 14;
  localparam logic [33:0] VECS [0:NV-1] = '{
    {1'b0, 32'h0000_0000, 1'b1},
    {1'b0, 32'h0000_0005, 1'b1},
    {1'b0, 32'h7FFF_FFFF, 1'b1},
    {1'b0, 32'h1234_5678, 1'b1},
    {1'b0, 32'h8000_0000, 1'b0},
    {1'b0, 32'hFFFF_FFFF, 1'b0},
    {1'b1, 32'h0000_0000, 1'b1},
    {1'b1, 32'hFFFF_FFFF, 1'b1},
    {1'b1, 32'h8000_0000, 1'b1},
    {1'b1, 32'h0000_0001, 1'b0},
    {1'b1, 32'h7FFF_FFFF, 1'b0},
    {1'b1, 32'h0001_0000, 1'b0},
    {1'b1, 32'h0000_0100, 1'b0},
    {1'b1, 32'h4000_0000, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_diff = '0; cmp_mode = 1'b0; cmp_load = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset value", cond_flag, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // table walk: R6 same-cycle condition, then R7 capture
    for (int i = 0; i < NV; i++) begin
      string tag;
      logic  m;
      logic [31:0] b;
      logic  e;
      m = VECS[i][33];
      b = VECS[i][32:1];
      e = VECS[i][0];
      if (!m)            tag = e ? "R1" : "R2";
      else if (b == '0)  tag = "R4";
      else               tag = e ? "R3" : "R5";
      @(negedge clk);
      cmp_mode = m; bus_diff = b;
      #1;
      check($sformatf("%s/R6 vec %0d", tag, i), cond_now, e);
      cmp_load = 1'b1;
      @(posedge clk);
      #1;
      check($sformatf("R7 vec %0d", i), cond_flag, e);
      cmp_load = 1'b0;
    end

    // R8: flag holds while load is low and live condition flips
    @(negedge clk);
    cmp_mode = 1'b0; bus_diff = 32'h0000_0010; cmp_load = 1'b1;
    @(posedge clk); #1;
    check("R7 load one", cond_flag, 1'b1);
    cmp_load = 1'b0;
    bus_diff = 32'h8000_0001;
    #1;
    check("R2 live flip", cond_now, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    check("R8 hold high", cond_flag, 1'b1);
    cmp_mode = 1'b1; bus_diff = 32'h0000_0002;
    @(negedge clk); cmp_load = 1'b1;
    @(posedge clk); #1;
    check("R7 load zero", cond_flag, 1'b0);
    cmp_load = 1'b0; bus_diff = 32'h0;
    #1;
    check("R4 live zero", cond_now, 1'b1);
    repeat (2) @(posedge clk);
    #1;
    check("R8 hold low", cond_flag, 1'b0);

    // R9: reset beats load
    @(negedge clk);
    cmp_load = 1'b1;
    @(posedge clk); #1;
    check("R7 set before reset", cond_flag, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R9 reset over load", cond_flag, 1'b0);
    @(negedge clk);
    rst = 1'b0; cmp_load = 1'b0;
    @(posedge clk); #1;
    check("R8 after reset", cond_flag, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule